// File: doc/BRIEF.md
# Dual-Input Up/Down Cascadable Counter

This block is a small binary counter with two separate count strobes. A rising edge on the up strobe adds one while the down strobe rests high. A rising edge on the down strobe subtracts one while the up strobe rests high. A synchronous clear and an active-low parallel load override the counting. The clear wins over the load, and the load wins over a count.

The block runs on one system clock. Each strobe passes through a two-flop synchronizer, and the block detects edges on the synchronized level. A count event is accepted only when the other strobe was high in the previous synchronized sample. Two active-low terminal outputs let counters be chained with no glue logic. The carry output goes low while the count is at its maximum and the synchronized up strobe is low. The borrow output goes low while the count is zero and the synchronized down strobe is low. Wire carry to the next stage's up strobe and borrow to its down strobe. Loading a preset value shortens the count cycle, so the block can act as a modulo-N divider.

Top module: `dual_pulse_counter`

## Requirements
- R1: A low-to-high change on `up_in` while `down_in` is high increments `count_o` by one. The new value appears at the third rising clock edge after the change is applied.
- R2: A low-to-high change on `down_in` while `up_in` is high decrements `count_o` by one, with the same three-edge latency.
- R3: A rising edge on one strobe while the other strobe is low leaves `count_o` unchanged.
- R4: While `load_n` is 0 and `clr` is 0, the next clock edge puts `data_in` on `count_o`, whatever the strobes do.
- R5: While `clr` is 1, the next clock edge sets `count_o` to 0, whatever `load_n` and the strobes do.
- R6: Counting up from 15 gives 0, and counting down from 0 gives 15.
- R7: `borrow_n` is 0 exactly when `count_o` is 0 and the down strobe, delayed by two clock edges, is 0.
- R8: `carry_n` is 0 exactly when `count_o` is 15 and the up strobe, delayed by two clock edges, is 0.
- R9: Two instances chained carry-to-up and borrow-to-down count as one 8-bit counter modulo 256, in both directions.
- R10: After synchronous reset `rst`, `count_o` is 0 and both `carry_n` and `borrow_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_in | input | 1 | Up count strobe, acts on its rising edge |
| down_in | input | 1 | Down count strobe, acts on its rising edge |
| clr | input | 1 | Active-high clear, highest priority |
| load_n | input | 1 | Active-low parallel load |
| data_in | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal count going up |
| borrow_n | output | 1 | Active-low terminal count going down |

## Verification
The hardest situation to reach from the ports is the carry ripple in a chained pair. There, the upper stage's strobe is the lower stage's terminal output. That output rises only when the lower stage leaves its maximum, or leaves zero going down, so the upper stage must count exactly once per wrap. The bench drives 20 up pulses and then 25 down pulses into a two-stage chain. This crosses the 15-to-16 boundary and the 0-to-255 wrap, and each strobe level is held long enough for both synchronizers to settle. The bench then compares the combined value with an integer modulo 256. A single instance is also checked every clock against a queue-based model, including the cases where one strobe rises while the other is low.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } dpc_step_e;
endpackage

// File: rtl/dpc_sync.sv
module dpc_sync #(
  parameter int STAGES   = 2,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{IDLE_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dpc_qualify.sv
module dpc_qualify
  import dpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      up_s,
  input  logic      dn_s,
  output dpc_step_e step
);
  logic up_prev, dn_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_prev <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_prev <= up_s;
      dn_prev <= dn_s;
    end
  end

  // an edge counts only if the other strobe rested high in the previous sample
  always_comb begin
    step = STEP_HOLD;
    if (up_s && !up_prev && dn_prev)      step = STEP_UP;
    else if (dn_s && !dn_prev && up_prev) step = STEP_DOWN;
  end
endmodule

// File: rtl/dpc_core.sv
module dpc_core
  import dpc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data,
  input  dpc_step_e        step,
  output logic [WIDTH-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (!load_n) cnt <= data;
    else begin
      case (step)
        STEP_UP:   cnt <= cnt + 1'b1;
        STEP_DOWN: cnt <= cnt - 1'b1;
        default:   cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dual_pulse_counter.sv
module dual_pulse_counter
  import dpc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_in,
  input  logic             down_in,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
  localparam int NCH = 2;

  logic [NCH-1:0] raw, synced;
  dpc_step_e      step;

  assign raw = {down_in, up_in};

  for (genvar g = 0; g < NCH; g++) begin : g_sync
    dpc_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d(raw[g]), .q(synced[g])
    );
  end

  dpc_qualify u_qual (
    .clk(clk), .rst(rst), .up_s(synced[0]), .dn_s(synced[1]), .step(step)
  );

  dpc_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .clr(clr), .load_n(load_n),
    .data(data_in), .step(step), .cnt(count_o)
  );

  // terminal outputs: decoded from flops only, gated by the synchronized strobe
  assign carry_n  = ~((count_o == TOP_VAL) & ~synced[0]);
  assign borrow_n = ~((count_o == '0)      & ~synced[1]);
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             load_n,
  input logic [WIDTH-1:0] data_in,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n,
  input logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_o == '0));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (count_o == $past(data_in)));

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n) |=> (count_o == $past(count_o)
                          || count_o == WIDTH'($past(count_o) + 1'b1)
                          || count_o == WIDTH'($past(count_o) - 1'b1)));

  p_carry_r8: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (count_o == TOP_VAL));

  p_borrow_r7: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (count_o == '0));
endmodule

bind dual_pulse_counter dpc_checker #(.WIDTH(WIDTH)) u_dpc_checker (
  .clk(clk), .rst(rst), .clr(clr), .load_n(load_n), .data_in(data_in),
  .count_o(count_o), .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/test_dual_pulse_counter.sv
`timescale 1ns/1ps
module test_dual_pulse_counter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, up = 1'b1, dn = 1'b1, clr = 1'b0, load_n = 1'b1;
  logic [3:0] data = 4'd0;
  logic [3:0] cnt;
  logic carry_n, borrow_n;

  dual_pulse_counter i_dual_pulse_counter (
    .clk(clk), .rst(rst), .up_in(up), .down_in(dn), .clr(clr),
    .load_n(load_n), .data_in(data), .count_o(cnt),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

  // cascade pair
  logic c_up = 1'b1, c_dn = 1'b1;
  logic [3:0] lo_cnt, hi_cnt;
  logic lo_carry, lo_borrow, hi_carry, hi_borrow;

  dual_pulse_counter i_lo (
    .clk(clk), .rst(rst), .up_in(c_up), .down_in(c_dn), .clr(1'b0),
    .load_n(1'b1), .data_in(4'd0), .count_o(lo_cnt),
    .carry_n(lo_carry), .borrow_n(lo_borrow)
  );
  dual_pulse_counter i_hi (
    .clk(clk), .rst(rst), .up_in(lo_carry), .down_in(lo_borrow), .clr(1'b0),
    .load_n(1'b1), .data_in(4'd0), .count_o(hi_cnt),
    .carry_n(hi_carry), .borrow_n(hi_borrow)
  );

  int checks = 0, errors = 0;
  string tag = "R10";
  bit cmp_en = 1'b0;

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // reference model: history queues of raw strobe levels
  int uq[$] = '{1, 1, 1};
  int dq[$] = '{1, 1, 1};
  int m_cnt = 0, m_carry = 1, m_borrow = 1;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0;
      uq = '{1, 1, 1};
      dq = '{1, 1, 1};
    end else begin
      bit ev_up, ev_dn;
      ev_up = uq[1] == 1 && uq[2] == 0 && dq[2] == 1;
      ev_dn = dq[1] == 1 && dq[2] == 0 && uq[2] == 1;
      if (clr)          m_cnt = 0;
      else if (!load_n) m_cnt = int'(data);
      else if (ev_up)   m_cnt = (m_cnt + 1) % 16;
      else if (ev_dn)   m_cnt = (m_cnt + 15) % 16;
      uq.push_front(int'(up)); void'(uq.pop_back());
      dq.push_front(int'(dn)); void'(dq.pop_back());
    end
    m_carry  = (m_cnt == 15 && uq[1] == 0) ? 0 : 1;
    m_borrow = (m_cnt == 0  && dq[1] == 0) ? 0 : 1;
    #2;
    if (cmp_en) begin
      check({tag, " count"}, int'(cnt), m_cnt);
      check({tag, " R8 carry"}, int'(carry_n), m_carry);
      check({tag, " R7 borrow"}, int'(borrow_n), m_borrow);
    end
  end

  task automatic pulse_up(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) up = 1'b0;
      repeat (3) @(negedge clk);
      up = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic pulse_dn(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) dn = 1'b0;
      repeat (3) @(negedge clk);
      dn = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic do_load(int v);
    @(negedge clk);
    data = 4'(v);
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  int c_exp = 0;
  task automatic cas_step(bit dir_up);
    @(negedge clk);
    if (dir_up) c_up = 1'b0; else c_dn = 1'b0;
    repeat (5) @(negedge clk);
    if (dir_up) c_up = 1'b1; else c_dn = 1'b1;
    repeat (10) @(negedge clk);
    c_exp = dir_up ? (c_exp + 1) % 256 : (c_exp + 255) % 256;
    check("R9 cascade", int'({hi_cnt, lo_cnt}), c_exp);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10 count", int'(cnt), 0);
    check("R10 carry", int'(carry_n), 1);
    check("R10 borrow", int'(borrow_n), 1);
    cmp_en = 1'b1;

    // R1: 5 up counts, with explicit latency check on the first one
    tag = "R1";
    @(negedge clk) up = 1'b0;
    repeat (3) @(negedge clk);
    up = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 before third edge", int'(cnt), 0);
    @(negedge clk);
    check("R1 at third edge", int'(cnt), 1);
    pulse_up(4);
    check("R1 after five", int'(cnt), 5);

    // R6 / R8: wrap going up through 15
    tag = "R4 R6 R8";
    do_load(14);
    check("R4 load", int'(cnt), 14);
    pulse_up(3);
    check("R6 up wrap", int'(cnt), 1);

    // R2 / R7: down through 0
    tag = "R2 R6 R7";
    do_load(2);
    pulse_dn(4);
    check("R2 R6 down wrap", int'(cnt), 14);

    // R3: edges with the other strobe low
    tag = "R3";
    @(negedge clk) dn = 1'b0;
    repeat (4) @(negedge clk);
    pulse_up(2);
    check("R3 up ignored", int'(cnt), 14);
    @(negedge clk) up = 1'b0;
    repeat (4) @(negedge clk);
    dn = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 down ignored", int'(cnt), 14);
    up = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 return counts up", int'(cnt), 15);

    // R5: clear beats load and counting
    tag = "R5";
    data = 4'd9;
    clr = 1'b1;
    load_n = 1'b0;
    @(negedge clk);
    check("R5 clear over load", int'(cnt), 0);
    clr = 1'b0;
    load_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: load held while counting
    tag = "R4";
    data = 4'd7;
    load_n = 1'b0;
    pulse_up(2);
    check("R4 load holds", int'(cnt), 7);
    load_n = 1'b1;
    pulse_up(1);
    check("R4 resume", int'(cnt), 8);

    // R9: cascade across 15->16 and 0->255
    tag = "R9";
    for (int i = 0; i < 20; i++) cas_step(1'b1);
    for (int i = 0; i < 25; i++) cas_step(1'b0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule